// File: doc/BRIEF.md
# Four-Set Direct-Mapped Tag Lookup

This block is a very small direct-mapped cache: four sets, each holding a valid flag, a two-bit tag and two bits of payload. It has no backing store and no refill path. Entries are placed by hand through a fill port that names the target set directly. A separate lookup port takes a four-bit address and reports whether that address is resident.

Four control inputs pick the operating mode. One exact combination arms the fill port, and a different exact combination arms the lookup port. Any other combination leaves the block idle. A fill is committed on the rising clock edge. A lookup is purely combinational: it splits the address into a set index and a tag, compares the tag with the indexed set, and drives the set's payload only when the result is a hit.

A synchronous reset marks every set empty, so every lookup misses until a valid entry has been filled.

Top module: `tiny_dm_cache`

## Requirements
- R1: The lookup address is split into two fields. Bits [1:0] select one of the four sets, and bits [3:2] are the tag compared against that set's stored tag.
- R2: When the fill combination is present at a rising edge, the set named by `way_sel_i` takes `fill_valid_i`, `fill_tag_i` and `fill_data_i`. The fill combination is `wr_mode_i`=1, `addr_src_i`=0, `fill_src_i`=0, `load_en_i`=1.
- R3: `hit_o` is 1 only when all three hold: the lookup combination is present, the indexed set's valid flag is 1, and its stored tag equals address bits [3:2]. The lookup combination is `wr_mode_i`=0, `addr_src_i`=1, `fill_src_i`=1, `load_en_i`=0.
- R4: Stored contents change only on a fill. Any control combination other than the exact fill combination, including the fill combination with `load_en_i`=0, leaves every set unchanged.
- R5: On a hit, `rdata_o` carries the indexed set's payload. On a miss, `rdata_o` is 0.
- R6: Whenever the controls are not exactly the lookup combination, `hit_o` is 0 and `rdata_o` is 0.
- R7: A synchronous reset clears every valid flag, and a fill presented while reset is high is dropped. Every lookup after reset misses until a valid entry has been filled.
- R8: Lookup outputs follow a change of address within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; fills commit on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_mode_i | input | 1 | Mode control bit (1 for fill, 0 for lookup) |
| addr_src_i | input | 1 | Address-path control bit (0 for fill, 1 for lookup) |
| fill_src_i | input | 1 | Payload-path control bit (0 for fill, 1 for lookup) |
| load_en_i | input | 1 | Storage write enable (1 for fill, 0 for lookup) |
| way_sel_i | input | 2 | Set targeted by a fill |
| fill_valid_i | input | 1 | Valid flag to store |
| fill_tag_i | input | 2 | Tag to store |
| fill_data_i | input | 2 | Payload to store |
| look_addr_i | input | 4 | Lookup address: tag in [3:2], set index in [1:0] |
| hit_o | output | 1 | 1 on a hit, 0 on a miss |
| rdata_o | output | 2 | Payload on a hit, zero otherwise |

## Verification
The assertions check several properties on every cycle. The payload is zero whenever the hit flag is low. Both outputs stay quiet outside lookup mode. A hit never comes from an empty set. Storage holds still on any cycle without a fill. A completed fill lands in the set it named, with the fields it carried. The first cycle after reset never hits.

The bench's scenarios cover what the assertions cannot see. These are tag mismatches against valid sets, and overwrites that evict an older tag. They also include near-miss control combinations and fills that carry a cleared valid flag. Finally, the bench shows that the outputs track the address inside a single cycle and that fills attempted under reset are lost.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_FILL = 2'd1,
    OP_LOOK = 2'd2
  } op_e;

  // Only two exact control patterns do anything; all others are idle.
  function automatic op_e classify_op(input logic wr_mode,
                                      input logic addr_src,
                                      input logic fill_src,
                                      input logic load_en);
    case ({wr_mode, addr_src, fill_src, load_en})
      4'b1001: classify_op = OP_FILL;
      4'b0110: classify_op = OP_LOOK;
      default: classify_op = OP_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/tdc_mode_dec.sv
module tdc_mode_dec
  import tdc_pkg::*;
(
  input  logic wr_mode_i,
  input  logic addr_src_i,
  input  logic fill_src_i,
  input  logic load_en_i,
  output logic fill_fire_o,
  output logic look_fire_o
);

  op_e op_w;

  assign op_w        = classify_op(wr_mode_i, addr_src_i, fill_src_i, load_en_i);
  assign fill_fire_o = (op_w == OP_FILL);
  assign look_fire_o = (op_w == OP_LOOK);

endmodule

// File: rtl/tdc_store.sv
module tdc_store #(
  parameter int TAG_W  = 2,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 2,
  localparam int SETS  = 1 << IDX_W,
  localparam int ENT_W = 1 + TAG_W + DATA_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  fill_fire_i,
  input  logic [IDX_W-1:0]      way_sel_i,
  input  logic                  fill_valid_i,
  input  logic [TAG_W-1:0]      fill_tag_i,
  input  logic [DATA_W-1:0]     fill_data_i,
  output logic [SETS*ENT_W-1:0] store_flat_o
);

  // Entry layout: {valid, tag, payload}
  function automatic logic [ENT_W-1:0] pack_entry(input logic            v,
                                                  input logic [TAG_W-1:0]  t,
                                                  input logic [DATA_W-1:0] d);
    pack_entry = {v, t, d};
  endfunction

  logic [ENT_W-1:0] new_ent_w;
  assign new_ent_w = pack_entry(fill_valid_i, fill_tag_i, fill_data_i);

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic             sel_w;
    logic [ENT_W-1:0] ent_q;

    assign sel_w = fill_fire_i && (way_sel_i == IDX_W'(s));

    always_ff @(posedge clk) begin
      if (rst) begin
        ent_q <= '0;
      end else if (sel_w) begin
        ent_q <= new_ent_w;
      end
    end

    assign store_flat_o[s*ENT_W +: ENT_W] = ent_q;
  end

endmodule

// File: rtl/tdc_match.sv
module tdc_match #(
  parameter int TAG_W  = 2,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 2,
  localparam int SETS   = 1 << IDX_W,
  localparam int ENT_W  = 1 + TAG_W + DATA_W,
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic [SETS*ENT_W-1:0] store_flat_i,
  input  logic [ADDR_W-1:0]     look_addr_i,
  input  logic                  look_fire_i,
  output logic                  hit_o,
  output logic [DATA_W-1:0]     rdata_o
);

  function automatic logic ent_valid(input logic [ENT_W-1:0] e);
    ent_valid = e[ENT_W-1];
  endfunction

  function automatic logic [TAG_W-1:0] ent_tag(input logic [ENT_W-1:0] e);
    ent_tag = e[ENT_W-2 -: TAG_W];
  endfunction

  function automatic logic [DATA_W-1:0] ent_data(input logic [ENT_W-1:0] e);
    ent_data = e[DATA_W-1:0];
  endfunction

  logic [IDX_W-1:0] idx_w;
  logic [TAG_W-1:0] tag_w;
  logic [ENT_W-1:0] sel_ent_w;
  logic             tag_eq_w;
  logic             ent_valid_w;
  logic             hit_w;

  assign idx_w = look_addr_i[IDX_W-1:0];
  assign tag_w = look_addr_i[ADDR_W-1:IDX_W];

  always_comb begin
    sel_ent_w = store_flat_i[idx_w*ENT_W +: ENT_W];
  end

  assign ent_valid_w = ent_valid(sel_ent_w);
  assign tag_eq_w    = (ent_tag(sel_ent_w) == tag_w);
  assign hit_w       = look_fire_i && ent_valid_w && tag_eq_w;

  assign hit_o   = hit_w;
  assign rdata_o = hit_w ? ent_data(sel_ent_w) : '0;

endmodule

// File: rtl/tiny_dm_cache.sv
module tiny_dm_cache #(
  parameter int TAG_W  = 2,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 2,
  localparam int SETS   = 1 << IDX_W,
  localparam int ENT_W  = 1 + TAG_W + DATA_W,
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_mode_i,
  input  logic              addr_src_i,
  input  logic              fill_src_i,
  input  logic              load_en_i,
  input  logic [IDX_W-1:0]  way_sel_i,
  input  logic              fill_valid_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic [ADDR_W-1:0] look_addr_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic                  fill_fire_w;
  logic                  look_fire_w;
  logic [SETS*ENT_W-1:0] store_flat_w;

  tdc_mode_dec u_dec (
    .wr_mode_i   (wr_mode_i),
    .addr_src_i  (addr_src_i),
    .fill_src_i  (fill_src_i),
    .load_en_i   (load_en_i),
    .fill_fire_o (fill_fire_w),
    .look_fire_o (look_fire_w)
  );

  tdc_store #(.TAG_W(TAG_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
    .clk          (clk),
    .rst          (rst),
    .fill_fire_i  (fill_fire_w),
    .way_sel_i    (way_sel_i),
    .fill_valid_i (fill_valid_i),
    .fill_tag_i   (fill_tag_i),
    .fill_data_i  (fill_data_i),
    .store_flat_o (store_flat_w)
  );

  tdc_match #(.TAG_W(TAG_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_match (
    .store_flat_i (store_flat_w),
    .look_addr_i  (look_addr_i),
    .look_fire_i  (look_fire_w),
    .hit_o        (hit_o),
    .rdata_o      (rdata_o)
  );

endmodule

// File: rtl/tdc_checker.sv
module tdc_checker #(
  parameter int TAG_W  = 2,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 2,
  localparam int SETS   = 1 << IDX_W,
  localparam int ENT_W  = 1 + TAG_W + DATA_W,
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  fill_fire,
  input logic                  look_fire,
  input logic [SETS*ENT_W-1:0] store_flat,
  input logic [IDX_W-1:0]      way_sel_i,
  input logic                  fill_valid_i,
  input logic [TAG_W-1:0]      fill_tag_i,
  input logic [DATA_W-1:0]     fill_data_i,
  input logic [ADDR_W-1:0]     look_addr_i,
  input logic                  hit_o,
  input logic [DATA_W-1:0]     rdata_o
);

  logic             prev_rst_q;
  logic             fire_q;
  logic [IDX_W-1:0] wsel_q;
  logic [ENT_W-1:0] went_q;

  always_ff @(posedge clk) begin
    prev_rst_q <= rst;
    fire_q     <= fill_fire && !rst;
    wsel_q     <= way_sel_i;
    went_q     <= {fill_valid_i, fill_tag_i, fill_data_i};
  end

  p_zero_on_miss_r5: assert property (@(posedge clk) disable iff (rst)
    !hit_o |-> (rdata_o == '0));

  p_quiet_outside_lookup_r6: assert property (@(posedge clk) disable iff (rst)
    !look_fire |-> (!hit_o && (rdata_o == '0)));

  p_hit_from_valid_set_r3: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> (look_fire && store_flat[look_addr_i[IDX_W-1:0]*ENT_W + ENT_W - 1]));

  p_hold_without_fill_r4: assert property (@(posedge clk) disable iff (rst)
    !fill_fire |=> $stable(store_flat));

  p_fill_lands_r2: assert property (@(posedge clk) disable iff (rst)
    fire_q |-> (store_flat[wsel_q*ENT_W +: ENT_W] == went_q));

  p_first_after_reset_misses_r7: assert property (@(posedge clk) disable iff (rst)
    prev_rst_q |-> !hit_o);

endmodule

bind tiny_dm_cache tdc_checker #(.TAG_W(TAG_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_tdc_chk (
  .clk          (clk),
  .rst          (rst),
  .fill_fire    (fill_fire_w),
  .look_fire    (look_fire_w),
  .store_flat   (store_flat_w),
  .way_sel_i    (way_sel_i),
  .fill_valid_i (fill_valid_i),
  .fill_tag_i   (fill_tag_i),
  .fill_data_i  (fill_data_i),
  .look_addr_i  (look_addr_i),
  .hit_o        (hit_o),
  .rdata_o      (rdata_o)
);

// File: tb/tiny_dm_cache_bench.sv
module tiny_dm_cache_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic       wr_mode_i, addr_src_i, fill_src_i, load_en_i;
  logic [1:0] way_sel_i;
  logic       fill_valid_i;
  logic [1:0] fill_tag_i, fill_data_i;
  logic [3:0] look_addr_i;
  logic       hit_o;
  logic [1:0] rdata_o;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 0;

  always #4 clk = ~clk;

  tiny_dm_cache u_tiny_dm_cache (
    .clk(clk), .rst(rst),
    .wr_mode_i(wr_mode_i), .addr_src_i(addr_src_i),
    .fill_src_i(fill_src_i), .load_en_i(load_en_i),
    .way_sel_i(way_sel_i), .fill_valid_i(fill_valid_i),
    .fill_tag_i(fill_tag_i), .fill_data_i(fill_data_i),
    .look_addr_i(look_addr_i), .hit_o(hit_o), .rdata_o(rdata_o)
  );

  localparam logic [3:0] FILL = 4'b1001;
  localparam logic [3:0] LOOK = 4'b0110;
  localparam int NROWS = 20;

  // {req[4], is_fill[1], ctl[4], way[2], v, tag[2], data[2], addr[4], exp_hit, exp_data[2]}
  localparam logic [22:0] ROWS [NROWS] = '{
    {4'd7, 1'b0, LOOK,    2'd0, 1'b0, 2'd0, 2'd0, 4'b1000, 1'b0, 2'd0},
    {4'd6, 1'b1, FILL,    2'd0, 1'b1, 2'd2, 2'd3, 4'b0000, 1'b0, 2'd0},
    {4'd2, 1'b0, LOOK,    2'd0, 1'b0, 2'd0, 2'd0, 4'b1000, 1'b1, 2'd3},
    {4'd1, 1'b0, LOOK,    2'd0, 1'b0, 2'd0, 2'd0, 4'b0100, 1'b0, 2'd0},
    {4'd3, 1'b0, LOOK,    2'd0, 1'b0, 2'd0, 2'd0, 4'b1001, 1'b0, 2'd0},
    {4'd6, 1'b1, FILL,    2'd1, 1'b1, 2'd1, 2'd2, 4'b0000, 1'b0, 2'd0},
    {4'd1, 1'b0, LOOK,    2'd0, 1'b0, 2'd0, 2'd0, 4'b0101, 1'b1, 2'd2},
    {4'd6, 1'b1, FILL,    2'd3, 1'b0, 2'd3, 2'd1, 4'b0000, 1'b0, 2'd0},
    {4'd3, 1'b0, LOOK,    2'd0, 1'b0, 2'd0, 2'd0, 4'b1111, 1'b0, 2'd0},
    {4'd6, 1'b1, 4'b1000, 2'd0, 1'b1, 2'd0, 2'd1, 4'b0000, 1'b0, 2'd0},
    {4'd4, 1'b0, LOOK,    2'd0, 1'b0, 2'd0, 2'd0, 4'b1000, 1'b1, 2'd3},
    {4'd6, 1'b1, 4'b1011, 2'd0, 1'b1, 2'd0, 2'd1, 4'b0000, 1'b0, 2'd0},
    {4'd4, 1'b0, LOOK,    2'd0, 1'b0, 2'd0, 2'd0, 4'b1000, 1'b1, 2'd3},
    {4'd6, 1'b0, 4'b0100, 2'd0, 1'b0, 2'd0, 2'd0, 4'b1000, 1'b0, 2'd0},
    {4'd6, 1'b0, 4'b1110, 2'd0, 1'b0, 2'd0, 2'd0, 4'b0101, 1'b0, 2'd0},
    {4'd6, 1'b1, FILL,    2'd0, 1'b1, 2'd3, 2'd1, 4'b0000, 1'b0, 2'd0},
    {4'd2, 1'b0, LOOK,    2'd0, 1'b0, 2'd0, 2'd0, 4'b1100, 1'b1, 2'd1},
    {4'd5, 1'b0, LOOK,    2'd0, 1'b0, 2'd0, 2'd0, 4'b1000, 1'b0, 2'd0},
    {4'd6, 1'b1, FILL,    2'd2, 1'b1, 2'd0, 2'd0, 4'b0000, 1'b0, 2'd0},
    {4'd5, 1'b0, LOOK,    2'd0, 1'b0, 2'd0, 2'd0, 4'b0010, 1'b1, 2'd0}
  };

  function automatic string req_name(input logic [3:0] n);
    case (n)
      4'd1: req_name = "R1";
      4'd2: req_name = "R2";
      4'd3: req_name = "R3";
      4'd4: req_name = "R4";
      4'd5: req_name = "R5";
      4'd6: req_name = "R6";
      4'd7: req_name = "R7";
      default: req_name = "R8";
    endcase
  endfunction

  task automatic set_ctl(input logic [3:0] c);
    {wr_mode_i, addr_src_i, fill_src_i, load_en_i} = c;
  endtask

  task automatic chk(input string req, input logic eh, input logic [1:0] ed);
    total++;
    if (hit_o !== eh || rdata_o !== ed) begin
      bad++;
      $display("FAIL %s: hit=%0b data=%0d, expected hit=%0b data=%0d",
               req, hit_o, rdata_o, eh, ed);
    end
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    set_ctl(LOOK);
    way_sel_i = 0; fill_valid_i = 0; fill_tag_i = 0; fill_data_i = 0;
    look_addr_i = 4'b0000;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R7", 1'b0, 2'd0);  // reset state: nothing hits
    rst = 1'b0;

    for (int i = 0; i < NROWS; i++) begin
      logic [22:0] r;
      r = ROWS[i];
      @(negedge clk);
      set_ctl(r[17:14]);
      way_sel_i    = r[13:12];
      fill_valid_i = r[11];
      fill_tag_i   = r[10:9];
      fill_data_i  = r[8:7];
      look_addr_i  = r[6:3];
      #2;
      chk(req_name(r[22:19]), r[2], r[1:0]);
    end

    // R8: outputs follow address changes inside one low phase
    @(negedge clk);
    set_ctl(LOOK);
    fill_valid_i = 0;
    look_addr_i = 4'b0101; #1; chk("R8", 1'b1, 2'd2);
    look_addr_i = 4'b1100; #1; chk("R8", 1'b1, 2'd1);
    look_addr_i = 4'b0010; #1; chk("R8", 1'b1, 2'd0);

    // R7: reset clears all sets and drops a concurrent fill
    @(negedge clk);
    rst = 1'b1;
    set_ctl(FILL);
    way_sel_i = 2'd1; fill_valid_i = 1; fill_tag_i = 2'd2; fill_data_i = 2'd3;
    @(negedge clk);
    rst = 1'b0;
    set_ctl(LOOK);
    fill_valid_i = 0;
    look_addr_i = 4'b1001; #1; chk("R7", 1'b0, 2'd0);
    look_addr_i = 4'b0101; #1; chk("R7", 1'b0, 2'd0);
    look_addr_i = 4'b1100; #1; chk("R7", 1'b0, 2'd0);
    look_addr_i = 4'b0010; #1; chk("R7", 1'b0, 2'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule